// File: doc/BRIEF.md
# Single-Precision to 24-bit Float Narrowing Converter

This block takes a 32-bit IEEE-754 binary value and produces a 24-bit floating-point value. The 24-bit result keeps the sign bit and the 8-bit biased exponent unchanged and carries 15 fraction bits. The 8 least significant fraction bits of the input are removed. A mode pin picks round-to-nearest-even or round-toward-zero.

Rounding uses the three bits next to the cut. The kept least significant bit is input fraction bit 8. The first dropped bit is fraction bit 7. The remaining dropped bits, fraction bits 6 to 0, are ORed together into a single sticky bit.

Rounding is a single increment on the concatenated exponent and fraction. A carry out of the fraction therefore moves into the exponent, so a value can leave its class:

- a subnormal can become the smallest normal number;
- a large finite value can become infinity.

Infinities and NaNs are handled on their own path. Two status outputs report whether the result is inexact and whether it overflowed to infinity. A new value is accepted on every cycle. The parameter `REG_OUT` selects either one register stage at the output or a purely combinational path.

Top module: `f32_to_f24_narrow`

## Requirements
- R1: In nearest-even mode (`rne_en`=1), a finite result is incremented when input bit 7 is 1 and any of bits 6..0 are 1.
- R2: In nearest-even mode, a finite result is not incremented when input bit 7 is 0, whatever the lower bits are.
- R3: In nearest-even mode, when bit 7 is 1 and bits 6..0 are all 0, the result is incremented only if input bit 8 is 1. This leaves the kept least significant bit at 0.
- R4: In toward-zero mode (`rne_en`=0), the output is input bits {31:8} unchanged, and `ovf` stays 0.
- R5: A rounding increment carries from the 15-bit fraction into the exponent. If the exponent reaches 0xFF, the output is a signed infinity (exponent 0xFF, fraction 0) and `ovf` is 1.
- R6: An infinity input (exponent 0xFF, fraction 0) gives an infinity of the same sign. Both flags are 0.
- R7: A NaN input (exponent 0xFF, fraction nonzero) gives a NaN whose fraction is input bits 22..8 with no increment. This keeps the quiet bit (output bit 14). Both flags are 0.
- R8: If those 15 NaN fraction bits are all zero, output bit 0 is set to 1 so that the result stays a NaN.
- R9: A subnormal input (exponent 0) either rounds to a signed zero or carries into the smallest normal value (exponent 1, fraction 0).
- R10: For a finite input, `inexact` is 1 exactly when input bits 7..0 are not all zero.
- R11: With `REG_OUT`=1, the outputs follow the input after one rising clock edge and hold between edges. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| src_val | input | 32 | Single-precision operand |
| rne_en | input | 1 | 1 = round to nearest even, 0 = round toward zero |
| res_val | output | 24 | Narrowed result {sign, exponent[7:0], fraction[14:0]} |
| inexact | output | 1 | Nonzero bits were discarded from a finite value |
| ovf | output | 1 | Finite input rounded up to infinity |

## Verification
Rounding and class change can occur in the same cycle: a single increment can make the result even and also carry into the exponent. Carry into the exponent can produce either infinity with the overflow flag or a new normal number from a subnormal. The bench provokes this with operands whose kept fraction is all ones and whose dropped bits form either a tie or an above-half pattern, using both signs. It judges the exact output word and both flags against values worked out by hand. It also applies the same operands in toward-zero mode to show that no class change occurs there.

// File: rtl/f32_to_f24_narrow.sv
module f32_to_f24_narrow #(
  parameter int EXP_W  = 8,
  parameter int SRC_FW = 23,
  parameter int DST_FW = 15,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [EXP_W+SRC_FW:0]      src_val,
  input  logic                       rne_en,
  output logic [EXP_W+DST_FW:0]      res_val,
  output logic                       inexact,
  output logic                       ovf
);
  localparam int CUT   = SRC_FW - DST_FW;
  localparam int MAG_W = EXP_W + DST_FW;

  logic                 sgn;
  logic [EXP_W-1:0]     expo;
  logic [SRC_FW-1:0]    frac;
  logic [DST_FW-1:0]    keep;
  logic                 lsb_k, rnd_b, stk_b, rup;
  logic                 exp_max, is_nan, is_inf;
  logic [MAG_W-1:0]     mag_sum;
  logic [DST_FW-1:0]    nan_frac;
  logic [MAG_W:0]       nxt_res;
  logic                 nxt_inx, nxt_ovf;

  assign sgn   = src_val[EXP_W+SRC_FW];
  assign expo  = src_val[SRC_FW +: EXP_W];
  assign frac  = src_val[SRC_FW-1:0];
  assign keep  = frac[SRC_FW-1:CUT];
  assign lsb_k = frac[CUT];
  assign rnd_b = frac[CUT-1];
  assign stk_b = |frac[CUT-2:0];

  assign exp_max = &expo;
  assign is_nan  = exp_max && (frac != '0);
  assign is_inf  = exp_max && (frac == '0);

  assign rup      = rne_en & rnd_b & (stk_b | lsb_k);
  assign mag_sum  = {expo, keep} + {{(MAG_W-1){1'b0}}, rup};
  assign nan_frac = keep | {{(DST_FW-1){1'b0}}, (keep == '0)};

  always_comb begin
    if (is_nan) begin
      nxt_res = {sgn, expo, nan_frac};
      nxt_inx = 1'b0;
      nxt_ovf = 1'b0;
    end else if (is_inf) begin
      nxt_res = {sgn, expo, {DST_FW{1'b0}}};
      nxt_inx = 1'b0;
      nxt_ovf = 1'b0;
    end else begin
      nxt_res = {sgn, mag_sum};
      nxt_inx = |frac[CUT-1:0];
      nxt_ovf = &mag_sum[MAG_W-1:DST_FW];
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res_val <= '0;
          inexact <= 1'b0;
          ovf     <= 1'b0;
        end else begin
          res_val <= nxt_res;
          inexact <= nxt_inx;
          ovf     <= nxt_ovf;
        end
      end
    end else begin : g_comb
      assign res_val = nxt_res;
      assign inexact = nxt_inx;
      assign ovf     = nxt_ovf;
    end
  endgenerate

  AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (res_val[MAG_W-1:0] == {{EXP_W{1'b1}}, {DST_FW{1'b0}}})); // R5
  AST_OVF_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> inexact); // R10
  AST_SPECIAL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ((&res_val[MAG_W-1:DST_FW]) && !ovf) |-> !inexact); // R6
  AST_NAN_STAYS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    is_nan |-> (nxt_res[DST_FW-1:0] != '0)); // R8
  AST_RTZ_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    !rne_en |-> !nxt_ovf); // R4
endmodule

// File: tb/f32_to_f24_narrow_tb.sv
module f32_to_f24_narrow_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_val = '0;
  logic        rne_en = 1'b1;
  logic [23:0] res_val;
  logic        inexact, ovf;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  f32_to_f24_narrow dut_i (
    .clk(clk), .rst_n(rst_n), .src_val(src_val), .rne_en(rne_en),
    .res_val(res_val), .inexact(inexact), .ovf(ovf));

  // {tag[23:0], mode, input[31:0], expected[23:0], inexact, ovf}
  localparam int NV = 32;
  localparam logic [82:0] VEC [NV] = '{
    {"R1 ", 1'b1, 32'h3F8000C1, 24'h3F8001, 1'b1, 1'b0},
    {"R1 ", 1'b1, 32'hC0490FDB, 24'hC04910, 1'b1, 1'b0},
    {"R2 ", 1'b1, 32'h3F80017F, 24'h3F8001, 1'b1, 1'b0},
    {"R2 ", 1'b1, 32'h3F800001, 24'h3F8000, 1'b1, 1'b0},
    {"R3 ", 1'b1, 32'h3F800080, 24'h3F8000, 1'b1, 1'b0},
    {"R3 ", 1'b1, 32'h3F800180, 24'h3F8002, 1'b1, 1'b0},
    {"R4 ", 1'b0, 32'h3F8001FF, 24'h3F8001, 1'b1, 1'b0},
    {"R4 ", 1'b0, 32'hC0490FDB, 24'hC0490F, 1'b1, 1'b0},
    {"R4 ", 1'b0, 32'h7F7FFFFF, 24'h7F7FFF, 1'b1, 1'b0},
    {"R4 ", 1'b0, 32'h3F800180, 24'h3F8001, 1'b1, 1'b0},
    {"R5 ", 1'b1, 32'h3FFFFF80, 24'h400000, 1'b1, 1'b0},
    {"R5 ", 1'b1, 32'h7F7FFFFF, 24'h7F8000, 1'b1, 1'b1},
    {"R5 ", 1'b1, 32'hFF7FFF80, 24'hFF8000, 1'b1, 1'b1},
    {"R5 ", 1'b1, 32'h7F7FFF7F, 24'h7F7FFF, 1'b1, 1'b0},
    {"R6 ", 1'b1, 32'h7F800000, 24'h7F8000, 1'b0, 1'b0},
    {"R6 ", 1'b1, 32'hFF800000, 24'hFF8000, 1'b0, 1'b0},
    {"R6 ", 1'b0, 32'hFF800000, 24'hFF8000, 1'b0, 1'b0},
    {"R7 ", 1'b1, 32'h7FC00000, 24'h7FC000, 1'b0, 1'b0},
    {"R7 ", 1'b1, 32'h7FFFFFFF, 24'h7FFFFF, 1'b0, 1'b0},
    {"R7 ", 1'b1, 32'h7F8001FF, 24'h7F8001, 1'b0, 1'b0},
    {"R8 ", 1'b1, 32'h7F800001, 24'h7F8001, 1'b0, 1'b0},
    {"R8 ", 1'b1, 32'hFF8000FF, 24'hFF8001, 1'b0, 1'b0},
    {"R8 ", 1'b0, 32'h7F800080, 24'h7F8001, 1'b0, 1'b0},
    {"R9 ", 1'b1, 32'h0000007F, 24'h000000, 1'b1, 1'b0},
    {"R9 ", 1'b1, 32'h007FFF80, 24'h008000, 1'b1, 1'b0},
    {"R9 ", 1'b1, 32'h807FFFC0, 24'h808000, 1'b1, 1'b0},
    {"R9 ", 1'b0, 32'h807FFFFF, 24'h807FFF, 1'b1, 1'b0},
    {"R10", 1'b1, 32'h3F800000, 24'h3F8000, 1'b0, 1'b0},
    {"R10", 1'b1, 32'h00000000, 24'h000000, 1'b0, 1'b0},
    {"R10", 1'b1, 32'h80000000, 24'h800000, 1'b0, 1'b0},
    {"R10", 1'b1, 32'h00000100, 24'h000001, 1'b0, 1'b0},
    {"R10", 1'b0, 32'h40490F00, 24'h40490F, 1'b0, 1'b0}
  };

  task automatic check(input logic [23:0] tag, input logic [25:0] act, input logic [25:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got res=%h inx=%b ovf=%b, expected res=%h inx=%b ovf=%b",
               tag, act[25:2], act[1], act[0], exp[25:2], exp[1], exp[0]);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_up();
  end

  initial begin
    // R11: reset clears outputs even with a nonzero operand present
    src_val = 32'h7F7FFFFF;
    repeat (3) @(negedge clk);
    check("R11", {res_val, inexact, ovf}, 26'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      rne_en  = VEC[i][58];
      src_val = VEC[i][57:26];
      @(negedge clk);
      check(VEC[i][82:59], {res_val, inexact, ovf}, VEC[i][25:0]);
    end

    // R11: one-edge latency and hold between edges
    rne_en  = 1'b1;
    src_val = 32'h7F7FFFFF;
    @(negedge clk);
    check("R11", {res_val, inexact, ovf}, {24'h7F8000, 1'b1, 1'b1});
    src_val = 32'h3F800000;
    #3;
    check("R11", {res_val, inexact, ovf}, {24'h7F8000, 1'b1, 1'b1});
    @(negedge clk);
    check("R11", {res_val, inexact, ovf}, {24'h3F8000, 1'b0, 1'b0});

    // R5 and R4: same operand in both modes, back to back
    src_val = 32'hFF7FFFFF;
    @(negedge clk);
    check("R5 ", {res_val, inexact, ovf}, {24'hFF8000, 1'b1, 1'b1});
    rne_en = 1'b0;
    @(negedge clk);
    check("R4 ", {res_val, inexact, ovf}, {24'hFF7FFF, 1'b1, 1'b0});

    // R11: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", {res_val, inexact, ovf}, 26'h0);
    finish_up();
  end
endmodule